// File: doc/BRIEF.md
# Two-Region Memory Attribute Matcher

This block decides the memory attributes of each processor reference that is not served by on-chip SRAM. Two programmable region registers each describe an address window: an 8-bit base, with a per-bit don't-care mask, over the top address byte. Each region also carries a privilege qualifier, a cache mode, a buffered-write enable and a write-protect bit. A reference that falls in an enabled, privilege-matching region takes that region's attributes. A reference that no region claims takes the cache mode and buffered-write setting held in a separate defaults register.

The registers are loaded through a small configuration port. Ordinary software may only write them, and only when it is privileged. A debug-mode master may both read and write them. Each access request carries an address, a read/write flag, a privilege flag and an "SRAM hit" flag from the SRAM address decoder. One clock later the block returns either an attribute strobe with the resolved attributes, or a protection-fault pulse when a write lands in a write-protected region.

Top module: `mem_attr_matcher`

## Requirements
- R1: After a synchronous active-low reset, both regions are disabled and read back as 0. The defaults register reads 0x0000_0040, which is cache mode 2'b10. All attribute outputs are 0.
- R2: Region bits are laid out as follows: base [31:24], mask [23:16], enable [15], privilege field [14:13], cache mode [6:5], buffered-write [4], write-protect [2]. A region matches when enable is 1 and, for every address bit 31..24, either the mask bit is 1 or the address bit equals the base bit. A matching region's cache mode, buffered-write and write-protect appear on the outputs, and attr_src gives 1 for region 0 and 2 for region 1.
- R3: The privilege field gates a region's match. 2'b00 lets only user references (req_super=0) match, 2'b01 lets only supervisor references match, and 2'b1x lets both match.
- R4: When both regions match, region 0 wins.
- R5: When no region matches, attr_src is 0. The cache mode comes from defaults bits [6:5] and buffered-write from defaults bit [4], with attr_wp 0.
- R6: A write reference whose winning region has write-protect set pulses attr_fault and suppresses attr_valid. A read of such a region gives attr_valid with attr_wp=1. attr_valid and attr_fault are never high together.
- R7: A reference with req_sram=1 bypasses the matcher: attr_valid, attr_fault and all attribute outputs stay 0.
- R8: A configuration write takes effect only when cfg_super or cfg_debug is 1. Writes from a user-mode master with no debug access leave every register unchanged.
- R9: cfg_rdata returns the selected register only while cfg_rd and cfg_debug are both 1, and is 0 otherwise. Bits outside the fields of R2 read 0 in a region register. Bits other than [6:4] read 0 in the defaults register.
- R10: Code 0x004 selects region 0, code 0x005 selects region 1, and code 0x002 selects the defaults register. Writes to any other code change nothing.
- R11: The result of a request appears on the outputs one clock after the request is sampled. A register write takes effect for requests presented in the cycle after the write, not for a request in the same cycle.
- R12: Any non-SRAM reference whose address bits [31:29] are 3'b111 must resolve to a non-cacheable mode, meaning cache-mode bit 1 is set. An assertion flags a configuration where this does not hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_code | input | CODE_W | Register select code |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_super | input | 1 | Configuration master is privileged |
| cfg_debug | input | 1 | Configuration master is in debug mode |
| cfg_rdata | output | 32 | Read data (combinational) |
| req_valid | input | 1 | Access request present |
| req_addr | input | ADDR_W | Access address |
| req_write | input | 1 | Access is a write |
| req_super | input | 1 | Access is privileged |
| req_sram | input | 1 | Access maps to on-chip SRAM |
| attr_valid | output | 1 | Attributes valid strobe |
| attr_fault | output | 1 | Write-protect fault strobe |
| attr_cm | output | 2 | Effective cache mode |
| attr_bwe | output | 1 | Effective buffered-write enable |
| attr_wp | output | 1 | Effective write-protect |
| attr_src | output | SRC_W | 0 defaults, 1 region 0, 2 region 1 |

## Verification
Every request result is due exactly one rising edge after the request is driven. The bench drives on a falling edge and compares the full output vector at the next falling edge, after the single output register has loaded. Debug reads are combinational, so they are sampled one time unit after being driven, within the same low phase. For the write-then-use case, the bench presents a request in the same cycle as a write and checks that it still sees the old setting, then checks that the next request sees the new one.

// File: rtl/mattr_pkg.sv
// Shared layout and types for the memory attribute matcher.
// Assumes 32-bit configuration registers and an 8-bit region compare field.
package mattr_pkg;
    localparam int REG_W    = 32;
    localparam int CMP_W    = 8;
    localparam int BASE_LSB = 24;
    localparam int MASK_LSB = 16;
    localparam int EN_BIT   = 15;
    localparam int SM_LSB   = 13;
    localparam int CM_LSB   = 5;
    localparam int BWE_BIT  = 4;
    localparam int WP_BIT   = 2;

    localparam logic [REG_W-1:0] REGION_WMASK = 32'hFFFF_E074;
    localparam logic [REG_W-1:0] DFLT_WMASK   = 32'h0000_0070;
    localparam logic [REG_W-1:0] DFLT_RESET   = 32'h0000_0040;

    typedef struct packed {
        logic [1:0] cm;
        logic       bwe;
        logic       wp;
    } attr_t;
endpackage

// File: rtl/mattr_cfg_regs.sv
// Region and defaults registers with privilege-qualified write and
// debug-only read. Assumes the select codes of the regions are consecutive.
module mattr_cfg_regs
    import mattr_pkg::*;
#(
    parameter int N_REGION  = 2,
    parameter int CODE_W    = 12,
    parameter int CODE_BASE = 4,
    parameter int DFLT_CODE = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_wr,
    input  logic                             cfg_rd,
    input  logic [CODE_W-1:0]                cfg_code,
    input  logic [REG_W-1:0]                 cfg_wdata,
    input  logic                             cfg_super,
    input  logic                             cfg_debug,
    output logic [REG_W-1:0]                 cfg_rdata,
    output logic [N_REGION-1:0][REG_W-1:0]   region_q,
    output logic [REG_W-1:0]                 dflt_q
);
    logic                wr_ok;
    logic [N_REGION-1:0] en_vec;

    assign wr_ok = cfg_wr & (cfg_super | cfg_debug);

    genvar g;
    generate
        for (g = 0; g < N_REGION; g++) begin : g_region
            // Hold one region word; reset clears its enable.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    region_q[g] <= '0;
                else if (wr_ok && cfg_code == CODE_W'(CODE_BASE + g))
                    region_q[g] <= cfg_wdata & REGION_WMASK;
            end
            assign en_vec[g] = region_q[g][EN_BIT];
        end
    endgenerate

    // Hold the fallback attributes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dflt_q <= DFLT_RESET;
        else if (wr_ok && cfg_code == CODE_W'(DFLT_CODE))
            dflt_q <= cfg_wdata & DFLT_WMASK;
    end

    // Return the selected register to a debug-mode reader only.
    always_comb begin
        cfg_rdata = '0;
        if (cfg_rd && cfg_debug) begin
            if (cfg_code == CODE_W'(DFLT_CODE))
                cfg_rdata = dflt_q;
            for (int i = 0; i < N_REGION; i++)
                if (cfg_code == CODE_W'(CODE_BASE + i))
                    cfg_rdata = region_q[i];
        end
    end

    // R8
    user_wr_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_super && !cfg_debug) |=> ($stable(region_q) && $stable(dflt_q)));

    // R1
    reset_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (en_vec == '0));
endmodule

// File: rtl/mattr_region_cmp.sv
// Compares the top address byte of a reference against one region word.
// Purely combinational; assumes the layout of mattr_pkg.
module mattr_region_cmp
    import mattr_pkg::*;
(
    input  logic [REG_W-1:0] region_word,
    input  logic [CMP_W-1:0] addr_top,
    input  logic             is_super,
    output logic             hit,
    output attr_t            attr
);
    logic [CMP_W-1:0] base;
    logic [CMP_W-1:0] mask;
    logic [1:0]       smode;
    logic             addr_ok;
    logic             priv_ok;
    logic             unused_bits;

    assign unused_bits = ^{region_word[12:7], region_word[3], region_word[1:0]};

    // Decide whether this region claims the reference.
    always_comb begin
        base     = region_word[BASE_LSB +: CMP_W];
        mask     = region_word[MASK_LSB +: CMP_W];
        smode    = region_word[SM_LSB +: 2];
        addr_ok  = &(mask | ~(addr_top ^ base));
        priv_ok  = smode[1] | (smode[0] == is_super);
        hit      = region_word[EN_BIT] & addr_ok & priv_ok;
        attr.cm  = region_word[CM_LSB +: 2];
        attr.bwe = region_word[BWE_BIT];
        attr.wp  = region_word[WP_BIT];
    end
endmodule

// File: rtl/mattr_prio.sv
// Picks the lowest-numbered hitting region, or the defaults when none hits.
// Assumes source code 0 means defaults and i+1 means region i.
module mattr_prio
    import mattr_pkg::*;
#(
    parameter int N_REGION = 2,
    parameter int SRC_W    = 2
) (
    input  logic [N_REGION-1:0]  hits,
    input  attr_t [N_REGION-1:0] reg_attr,
    input  attr_t                dflt_attr,
    output attr_t                eff,
    output logic [SRC_W-1:0]     src
);
    // Walk from the highest index down so region 0 is the last word.
    always_comb begin
        eff = dflt_attr;
        src = '0;
        for (int i = N_REGION - 1; i >= 0; i--) begin
            if (hits[i]) begin
                eff = reg_attr[i];
                src = SRC_W'(i + 1);
            end
        end
    end
endmodule

// File: rtl/mem_attr_matcher.sv
// Top of the memory attribute matcher: configuration registers, one
// comparator per region, a priority pick and one output register stage.
// Assumes the SRAM decoder flags SRAM references before they arrive here.
module mem_attr_matcher
    import mattr_pkg::*;
#(
    parameter int N_REGION = 2,
    parameter int ADDR_W   = 32,
    parameter int CODE_W   = 12,
    localparam int SRC_W   = $clog2(N_REGION + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [CODE_W-1:0] cfg_code,
    input  logic [31:0]       cfg_wdata,
    input  logic              cfg_super,
    input  logic              cfg_debug,
    output logic [31:0]       cfg_rdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_super,
    input  logic              req_sram,
    output logic              attr_valid,
    output logic              attr_fault,
    output logic [1:0]        attr_cm,
    output logic              attr_bwe,
    output logic              attr_wp,
    output logic [SRC_W-1:0]  attr_src
);
    logic [N_REGION-1:0][REG_W-1:0] region_q;
    logic [REG_W-1:0]               dflt_q;
    logic [N_REGION-1:0]            hits;
    attr_t [N_REGION-1:0]           reg_attr;
    attr_t                          dflt_attr;
    attr_t                          eff;
    logic [SRC_W-1:0]               src;
    logic [CMP_W-1:0]               addr_top;
    logic                           lookup_go;
    logic                           fault_d;
    logic                           unused_addr;
    logic                           unused_dflt;

    assign unused_addr = ^req_addr[ADDR_W-CMP_W-1:0];
    assign unused_dflt = ^{dflt_q[REG_W-1:7], dflt_q[3:0]};

    mattr_cfg_regs #(
        .N_REGION (N_REGION),
        .CODE_W   (CODE_W),
        .CODE_BASE(4),
        .DFLT_CODE(2)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_rd   (cfg_rd),
        .cfg_code (cfg_code),
        .cfg_wdata(cfg_wdata),
        .cfg_super(cfg_super),
        .cfg_debug(cfg_debug),
        .cfg_rdata(cfg_rdata),
        .region_q (region_q),
        .dflt_q   (dflt_q)
    );

    assign addr_top = req_addr[ADDR_W-1 -: CMP_W];

    genvar g;
    generate
        for (g = 0; g < N_REGION; g++) begin : g_cmp
            mattr_region_cmp u_cmp (
                .region_word(region_q[g]),
                .addr_top   (addr_top),
                .is_super   (req_super),
                .hit        (hits[g]),
                .attr       (reg_attr[g])
            );
        end
    endgenerate

    assign dflt_attr = '{cm: dflt_q[CM_LSB +: 2], bwe: dflt_q[BWE_BIT], wp: 1'b0};

    mattr_prio #(
        .N_REGION(N_REGION),
        .SRC_W   (SRC_W)
    ) u_prio (
        .hits     (hits),
        .reg_attr (reg_attr),
        .dflt_attr(dflt_attr),
        .eff      (eff),
        .src      (src)
    );

    assign lookup_go = req_valid & ~req_sram;
    assign fault_d   = lookup_go & req_write & eff.wp;

    // Register the resolved attributes and the strobes for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            attr_valid <= 1'b0;
            attr_fault <= 1'b0;
            attr_cm    <= '0;
            attr_bwe   <= 1'b0;
            attr_wp    <= 1'b0;
            attr_src   <= '0;
        end else begin
            attr_valid <= lookup_go & ~fault_d;
            attr_fault <= fault_d;
            attr_cm    <= lookup_go ? eff.cm  : 2'b00;
            attr_bwe   <= lookup_go & eff.bwe;
            attr_wp    <= lookup_go & eff.wp;
            attr_src   <= lookup_go ? src : '0;
        end
    end

    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(attr_valid && attr_fault));

    // R6
    fault_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        attr_fault |-> $past(req_valid && req_write));

    // R7
    sram_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_sram) |=> (!attr_valid && !attr_fault && attr_src == '0));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!attr_valid && !attr_fault));

    // R12
    periph_noncache_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_go && req_addr[ADDR_W-1 -: 3] == 3'b111) |=> attr_cm[1]);
endmodule

// File: tb/mem_attr_matcher_bench.sv
// Self-checking bench: directed corner cases plus a sweep over the top
// address byte, privilege and direction for several region setups.
module mem_attr_matcher_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 0, cfg_rd = 0, cfg_super = 0, cfg_debug = 0;
    logic [11:0] cfg_code = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 0, req_write = 0, req_super = 0, req_sram = 0;
    logic [31:0] req_addr = '0;
    logic        attr_valid, attr_fault, attr_bwe, attr_wp;
    logic [1:0]  attr_cm, attr_src;

    int n_checks = 0;
    int n_err = 0;

    logic [31:0] m_reg [2];
    logic [31:0] m_dflt;

    always #(CLK_P/2) clk = ~clk;

    mem_attr_matcher u_mem_attr_matcher (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_code(cfg_code), .cfg_wdata(cfg_wdata),
        .cfg_super(cfg_super), .cfg_debug(cfg_debug), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .req_super(req_super), .req_sram(req_sram),
        .attr_valid(attr_valid), .attr_fault(attr_fault), .attr_cm(attr_cm),
        .attr_bwe(attr_bwe), .attr_wp(attr_wp), .attr_src(attr_src)
    );

    function automatic logic [31:0] mk_region(input logic [7:0] base, input logic [7:0] mask,
        input logic en, input logic [1:0] sm, input logic [1:0] cm, input logic bwe, input logic wp);
        return {base, mask, en, sm, 6'b0, cm, bwe, 1'b0, wp, 2'b0};
    endfunction

    // Expected {valid, fault, cm, bwe, wp, src} from the requirements.
    function automatic logic [7:0] model(input logic [31:0] a, input logic wr,
                                         input logic sup, input logic sram);
        logic [1:0] cm;
        logic       bwe, wp, fault;
        logic [1:0] src;
        logic [7:0] b, m;
        if (sram) return 8'h00;
        cm = m_dflt[6:5]; bwe = m_dflt[4]; wp = 1'b0; src = 2'd0;
        for (int i = 1; i >= 0; i--) begin
            b = m_reg[i][31:24];
            m = m_reg[i][23:16];
            if (m_reg[i][15] && ((a[31:24] & ~m) == (b & ~m)) &&
                (m_reg[i][14] || (m_reg[i][13] == sup))) begin
                cm = m_reg[i][6:5]; bwe = m_reg[i][4]; wp = m_reg[i][2];
                src = 2'(i + 1);
            end
        end
        fault = wr & wp;
        return {~fault, fault, cm, bwe, wp, src};
    endfunction

    function automatic logic [7:0] out_vec();
        return {attr_valid, attr_fault, attr_cm, attr_bwe, attr_wp, attr_src};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [11:0] code, input logic [31:0] d,
                             input logic sup, input logic dbg);
        @(negedge clk);
        cfg_wr = 1; cfg_code = code; cfg_wdata = d; cfg_super = sup; cfg_debug = dbg;
        @(negedge clk);
        cfg_wr = 0; cfg_super = 0; cfg_debug = 0;
        if (sup || dbg) begin
            if (code == 12'h004) m_reg[0] = d & 32'hFFFF_E074;
            if (code == 12'h005) m_reg[1] = d & 32'hFFFF_E074;
            if (code == 12'h002) m_dflt   = d & 32'h0000_0070;
        end
    endtask

    task automatic cfg_read(input logic [11:0] code, input logic dbg, input logic sup,
                            output logic [31:0] d);
        @(negedge clk);
        cfg_rd = 1; cfg_code = code; cfg_debug = dbg; cfg_super = sup;
        #1 d = cfg_rdata;
        cfg_rd = 0; cfg_debug = 0; cfg_super = 0;
    endtask

    task automatic access(input logic [31:0] a, input logic wr, input logic sup,
                          input logic sram, input string tag);
        logic [7:0] exp;
        exp = model(a, wr, sup, sram);
        @(negedge clk);
        req_valid = 1; req_addr = a; req_write = wr; req_super = sup; req_sram = sram;
        @(negedge clk);
        req_valid = 0; req_write = 0; req_sram = 0;
        check(tag, {24'h0, out_vec()}, {24'h0, exp});
    endtask

    task automatic regs_match(input string tag);
        logic [31:0] d;
        cfg_read(12'h004, 1, 0, d); check(tag, d, m_reg[0]);
        cfg_read(12'h005, 1, 0, d); check(tag, d, m_reg[1]);
        cfg_read(12'h002, 1, 0, d); check(tag, d, m_dflt);
    endtask

    initial begin : watchdog
        #(CLK_P * 200000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        logic [7:0]  e_old, e_new;
        logic [7:0]  msk;
        m_reg[0] = '0; m_reg[1] = '0; m_dflt = 32'h40;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        check("R1 outputs", {24'h0, out_vec()}, 32'h0);
        regs_match("R1 regs");
        access(32'h1234_5678, 0, 1, 0, "R1 default access");

        // R3 privilege field
        cfg_write(12'h004, mk_region(8'h10, 8'h00, 1, 2'b00, 2'b01, 0, 0), 1, 0);
        access(32'h1000_0000, 0, 0, 0, "R3 user-only user");
        access(32'h1000_0000, 0, 1, 0, "R3 user-only super");
        cfg_write(12'h004, mk_region(8'h10, 8'h00, 1, 2'b01, 2'b01, 0, 0), 1, 0);
        access(32'h1000_0000, 0, 0, 0, "R3 super-only user");
        access(32'h1000_0000, 0, 1, 0, "R3 super-only super");
        cfg_write(12'h004, mk_region(8'h10, 8'h00, 1, 2'b11, 2'b01, 0, 0), 1, 0);
        access(32'h1000_0000, 0, 0, 0, "R3 both user");
        check("R3 both user src", {30'h0, attr_src}, 32'd1);

        // R4 priority, R5 default
        cfg_write(12'h004, mk_region(8'h20, 8'h0F, 1, 2'b10, 2'b00, 1, 0), 1, 0);
        cfg_write(12'h005, mk_region(8'h20, 8'hFF, 1, 2'b10, 2'b11, 0, 0), 1, 0);
        access(32'h2500_0000, 0, 1, 0, "R4 overlap");
        check("R4 winner", {30'h0, attr_src}, 32'd1);
        access(32'h7000_0000, 0, 1, 0, "R4 region1 only");
        cfg_write(12'h005, 32'h0, 1, 0);
        cfg_write(12'h002, 32'h0000_0030, 1, 0);
        access(32'h7000_0000, 0, 0, 0, "R5 fallback");
        check("R5 src", {30'h0, attr_src}, 32'd0);

        // R6 write protect
        cfg_write(12'h004, mk_region(8'h30, 8'h00, 1, 2'b10, 2'b01, 0, 1), 1, 0);
        access(32'h3000_0010, 1, 1, 0, "R6 write fault");
        check("R6 fault bit", {31'h0, attr_fault}, 32'd1);
        access(32'h3000_0010, 0, 1, 0, "R6 read wp");

        // R7 SRAM bypass
        access(32'h3000_0010, 1, 1, 1, "R7 sram write");
        access(32'h7000_0000, 0, 0, 1, "R7 sram read");

        // R8 write privilege
        cfg_write(12'h004, 32'hA5A5_FFFF, 0, 0);
        regs_match("R8 user write ignored");
        cfg_write(12'h005, mk_region(8'h50, 8'h01, 1, 2'b00, 2'b10, 1, 0), 0, 1);
        regs_match("R8 debug write");

        // R9 read rules and reserved bits
        cfg_read(12'h005, 0, 1, d); check("R9 no-debug read", d, 32'h0);
        cfg_write(12'h004, 32'hFFFF_FFFF, 1, 0);
        cfg_read(12'h004, 1, 0, d); check("R9 reserved region", d, 32'hFFFF_E074);
        cfg_write(12'h002, 32'hFFFF_FFFF, 1, 0);
        cfg_read(12'h002, 1, 0, d); check("R9 reserved defaults", d, 32'h0000_0070);

        // R10 codes
        cfg_write(12'h006, 32'h1234_5678, 1, 0);
        cfg_write(12'h000, 32'h8765_4321, 0, 1);
        regs_match("R10 unused codes");
        cfg_read(12'h006, 1, 0, d); check("R10 unused read", d, 32'h0);

        // R11 write timing relative to requests
        cfg_write(12'h004, 32'h0, 1, 0);
        cfg_write(12'h005, 32'h0, 1, 0);
        cfg_write(12'h002, 32'h40, 1, 0);
        e_old = model(32'h3000_0000, 0, 1, 0);
        @(negedge clk);
        cfg_wr = 1; cfg_super = 1; cfg_code = 12'h004;
        cfg_wdata = mk_region(8'h30, 8'h00, 1, 2'b10, 2'b01, 1, 0);
        req_valid = 1; req_addr = 32'h3000_0000; req_write = 0; req_super = 1;
        m_reg[0] = cfg_wdata & 32'hFFFF_E074;
        e_new = model(32'h3000_0000, 0, 1, 0);
        @(negedge clk);
        cfg_wr = 0; cfg_super = 0;
        check("R11 same-cycle write", {24'h0, out_vec()}, {24'h0, e_old});
        @(negedge clk);
        req_valid = 0;
        check("R11 next request", {24'h0, out_vec()}, {24'h0, e_new});
        @(negedge clk);
        check("R11 idle", {24'h0, out_vec()}, 32'h0);

        // R2 sweep over top byte, privilege and direction (below 0xE0)
        for (int c = 0; c < 6; c++) begin
            msk = (c % 3 == 0) ? 8'h0F : ((c % 3 == 1) ? 8'h00 : 8'h30);
            cfg_write(12'h004, mk_region(8'h40 + 8'(c * 16), msk, 1, 2'(c), 2'(c), c[0], c[0]), 1, 0);
            cfg_write(12'h005, mk_region(8'h40, 8'h3F, (c != 5), 2'(c + 1), 2'(3 - c), ~c[0], 1'b0), 1, 0);
            cfg_write(12'h002, 32'((c % 4) << 4), 1, 0);
            for (int t = 0; t < 224; t++)
                for (int m = 0; m < 4; m++)
                    access({8'(t), 24'(t * 499)}, m[0], m[1], 0, "R2 sweep");
        end

        // R12 peripheral space stays non-cacheable
        cfg_write(12'h002, 32'h40, 1, 0);
        cfg_write(12'h004, 32'h0, 1, 0);
        cfg_write(12'h005, mk_region(8'hE0, 8'h1F, 1, 2'b10, 2'b11, 0, 0), 1, 0);
        access(32'hF000_0000, 0, 1, 0, "R12 region");
        access(32'hE800_0004, 1, 0, 0, "R12 region write");
        cfg_write(12'h005, 32'h0, 1, 0);
        access(32'hFFFF_0000, 0, 1, 0, "R12 defaults");
        check("R12 noncacheable", {31'h0, attr_cm[1]}, 32'd1);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule